// File: doc/BRIEF.md
# Configuration Access Command Translator

This host-side block turns register accesses into command cycles on a PCI-style multiplexed address/data bus. Software first writes a configuration address register. It then reads or writes a configuration data window. The block translates each window access into a bus cycle. The cycle starts with an address phase, which carries the command code on the command/byte-enable lines and an address on the address/data lines. A data phase follows, which carries the byte enables and, for writes, the data.

One configuration address is reserved: bus 0, device and function all ones, register 0. While that value is stored, a window read becomes an interrupt acknowledge cycle and a window write becomes a special cycle. A separate interrupt-acknowledge register starts an interrupt acknowledge cycle on any read, whatever address is stored. The cycle ends on the clock where the target signals ready. For reads, the bus value is captured on that clock and presented as returned data, which is the interrupt vector in the case of an interrupt acknowledge. Parity output follows each driven phase by one clock. Bus arbitration and electrical timing are handled elsewhere.

Top module: `cfg_cmd_xlate`

## Requirements
- R1: After a synchronous active-low reset, `cyc_start`, `busy`, `rd_valid`, `par_out`, `cbe_out` and `ad_out` are all zero.
- R2: A write with `reg_sel`=2'b00 stores the configuration address at any time, even while a cycle is running. A cycle that has already started keeps the address it captured when it was accepted.
- R3: A data-window access (`reg_sel`=2'b01) with a non-reserved stored address issues a configuration cycle. A read uses command 4'b1010 and a write uses command 4'b1011. The address phase drives the stored address with bits 1:0 forced to zero. The data phase of a write drives the write data.
- R4: The stored address is reserved when bits 23:16 are 0x00, bits 15:11 are all ones, bits 10:8 are all ones and bits 7:2 are zero. Bits 31:24 and 1:0 take no part in the test. With a reserved address, a data-window read issues command 4'b0000 (interrupt acknowledge) and its address phase drives all zeros.
- R5: With a reserved address, a data-window write issues command 4'b0001 (special cycle). Its address phase drives all zeros and its data phase drives the write data.
- R6: A read with `reg_sel`=2'b10 issues an interrupt acknowledge (4'b0000, zero address) whatever address is stored. A write with `reg_sel`=2'b10, and any access with `reg_sel`=2'b11, starts no cycle.
- R7: During the data phase, `cbe_out` carries the byte enables given with the access.
- R8: `par_out` in each cycle equals the XOR of `ad_out` and `cbe_out` from the previous cycle, so the ones across the pair plus parity form an even count.
- R9: `trdy` high during the data phase ends the cycle at that clock. For a read, `ad_in` is captured and `rd_valid` pulses for one cycle with it on `rd_data`. `trdy` outside a data phase has no effect.
- R10: `busy` rises with the address phase and falls after the completing clock. Data-window and interrupt-acknowledge accesses presented while `busy` is high are dropped.
- R11: `cyc_start` is high for exactly one cycle: the cycle after an access is accepted. That cycle is the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access presented this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 2 | 00 address reg, 01 data window, 10 interrupt-ack reg, 11 none |
| reg_wdata | input | DATA_W | Write data |
| reg_be | input | DATA_W/8 | Byte enables for the data phase |
| trdy | input | 1 | Target ready |
| ad_in | input | DATA_W | Bus value returned by the target |
| cyc_start | output | 1 | Address-phase strobe |
| cbe_out | output | DATA_W/8 | Command in address phase, byte enables in data phase |
| ad_out | output | DATA_W | Address/data lines driven by the block |
| par_out | output | 1 | Even parity of the previous cycle's ad_out and cbe_out |
| busy | output | 1 | Cycle in progress |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Captured read data or interrupt vector |

## Verification
A wrong reserved-pattern decode or a stale stored address shows up on `cbe_out` and `ad_out` during the address phase. That is the cycle right after the window access, so the error appears within one clock. A stuck or misordered phase state shows the next cycle as a wrong byte-enable value or a missing `cyc_start`. It can also show as an extra, unexpected strobe while `busy` is high. A lost capture path shows on the `rd_valid` pulse one clock after `trdy`. Parity errors are visible one cycle after the phase they cover.

// File: rtl/cfg_cmd_pkg.sv
// Shared types for the configuration command translator.
// Assumes a 32-bit-style address layout with fixed field positions.
package cfg_cmd_pkg;

    typedef enum logic [3:0] {
        CMD_INTACK  = 4'b0000,
        CMD_SPECIAL = 4'b0001,
        CMD_CFG_RD  = 4'b1010,
        CMD_CFG_WR  = 4'b1011
    } bus_cmd_e;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'b00,
        SEL_DATA = 2'b01,
        SEL_IACK = 2'b10,
        SEL_NONE = 2'b11
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_ADDR = 2'b01,
        PH_DATA = 2'b10
    } phase_e;

    // Field positions inside the stored configuration address.
    localparam int BUS_LO = 16;
    localparam int BUS_HI = 23;
    localparam int DEV_LO = 11;
    localparam int DEV_HI = 15;
    localparam int FN_LO  = 8;
    localparam int FN_HI  = 10;
    localparam int REG_LO = 2;
    localparam int REG_HI = 7;

endpackage

// File: rtl/cfg_addr_reg.sv
// Holds the configuration address and flags the reserved pattern.
// Assumes DATA_W >= 24 so that every address field exists.
module cfg_addr_reg
    import cfg_cmd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] addr_q,
    output logic              reserved_hit
);

    // Store the address on every address-register write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (wr_en)
            addr_q <= wdata;
    end

    // Decode the reserved pattern from the stored value.
    always_comb begin
        reserved_hit = (addr_q[BUS_HI:BUS_LO] == '0)
                    && (&addr_q[DEV_HI:DEV_LO])
                    && (&addr_q[FN_HI:FN_LO])
                    && (addr_q[REG_HI:REG_LO] == '0);
    end

endmodule

// File: rtl/cfg_cmd_decode.sv
// Turns a register access into a cycle launch request with command and bus values.
// Purely combinational. Assumes busy comes from the phase sequencer.
module cfg_cmd_decode
    import cfg_cmd_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_sel,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [BE_W-1:0]   acc_be,
    input  logic              busy,
    input  logic [DATA_W-1:0] addr_q,
    input  logic              reserved_hit,
    output logic              launch,
    output logic              addr_wr,
    output logic [3:0]        cmd,
    output logic [DATA_W-1:0] ad_addr,
    output logic [DATA_W-1:0] ad_data,
    output logic [BE_W-1:0]   be,
    output logic              is_read
);

    localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-2){1'b1}}, 2'b00};

    reg_sel_e sel;
    assign sel = reg_sel_e'(acc_sel);

    // Address-register writes are always taken.
    always_comb addr_wr = acc_valid && acc_write && (sel == SEL_ADDR);

    // Choose the command and the address-phase value for a launchable access.
    always_comb begin
        launch  = 1'b0;
        cmd     = CMD_CFG_RD;
        ad_addr = '0;
        if (acc_valid && !busy) begin
            if (sel == SEL_DATA) begin
                launch = 1'b1;
                if (reserved_hit) begin
                    cmd     = acc_write ? CMD_SPECIAL : CMD_INTACK;
                    ad_addr = '0;
                end else begin
                    cmd     = acc_write ? CMD_CFG_WR : CMD_CFG_RD;
                    ad_addr = addr_q & LOW_MASK;
                end
            end else if (sel == SEL_IACK && !acc_write) begin
                launch  = 1'b1;
                cmd     = CMD_INTACK;
                ad_addr = '0;
            end
        end
    end

    // Data-phase values come straight from the access.
    always_comb begin
        ad_data = acc_write ? acc_wdata : '0;
        be      = acc_be;
        is_read = !acc_write;
    end

endmodule

// File: rtl/cfg_bus_seq.sv
// Runs the address and data phases, drives the bus, generates parity and captures read data.
// Assumes at most one cycle in flight. A launch is only offered when idle.
module cfg_bus_seq
    import cfg_cmd_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [3:0]        cmd,
    input  logic [DATA_W-1:0] ad_addr,
    input  logic [DATA_W-1:0] ad_data,
    input  logic [BE_W-1:0]   be,
    input  logic              is_read,
    input  logic              trdy,
    input  logic [DATA_W-1:0] ad_in,
    output logic              cyc_start,
    output logic              busy,
    output logic [BE_W-1:0]   cbe_out,
    output logic [DATA_W-1:0] ad_out,
    output logic              par_out,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    phase_e            phase;
    logic [3:0]        cmd_q;
    logic [DATA_W-1:0] adr_q;
    logic [DATA_W-1:0] dat_q;
    logic [BE_W-1:0]   be_q;
    logic              rd_q;
    logic              done;

    always_comb done = (phase == PH_DATA) && trdy;

    // Phase progression: idle -> address -> data (held until target ready).
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= PH_IDLE;
        else begin
            unique case (phase)
                PH_IDLE: if (launch) phase <= PH_ADDR;
                PH_ADDR: phase <= PH_DATA;
                PH_DATA: if (trdy) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Capture the cycle description at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            adr_q <= '0;
            dat_q <= '0;
            be_q  <= '0;
            rd_q  <= 1'b0;
        end else if (phase == PH_IDLE && launch) begin
            cmd_q <= cmd;
            adr_q <= ad_addr;
            dat_q <= ad_data;
            be_q  <= be;
            rd_q  <= is_read;
        end
    end

    // Drive the multiplexed lines by phase.
    always_comb begin
        cyc_start = (phase == PH_ADDR);
        busy      = (phase != PH_IDLE);
        cbe_out   = '0;
        ad_out    = '0;
        if (phase == PH_ADDR) begin
            cbe_out = cmd_q;
            ad_out  = adr_q;
        end else if (phase == PH_DATA) begin
            cbe_out = be_q;
            ad_out  = dat_q;
        end
    end

    // Parity lags the driven lines by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            par_out <= 1'b0;
        else
            par_out <= ^{ad_out, cbe_out};
    end

    // Capture returned data when the target completes a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= done && rd_q;
            if (done && rd_q)
                rd_data <= ad_in;
        end
    end

    // R11
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> (!cyc_start && busy));

    // R9
    rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !busy);

    // R7
    data_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cyc_start) |-> (cbe_out == be_q));

endmodule

// File: rtl/cfg_cmd_xlate.sv
// Top: converts configuration-address/data-window and interrupt-ack register
// accesses into bus command cycles. Assumes one register access per clock.
module cfg_cmd_xlate
    import cfg_cmd_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [BE_W-1:0]   reg_be,
    input  logic              trdy,
    input  logic [DATA_W-1:0] ad_in,
    output logic              cyc_start,
    output logic [BE_W-1:0]   cbe_out,
    output logic [DATA_W-1:0] ad_out,
    output logic              par_out,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] addr_q;
    logic              reserved_hit;
    logic              launch;
    logic              addr_wr;
    logic [3:0]        cmd;
    logic [DATA_W-1:0] ad_addr;
    logic [DATA_W-1:0] ad_data;
    logic [BE_W-1:0]   be;
    logic              is_read;

    cfg_addr_reg #(.DATA_W(DATA_W)) u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (addr_wr),
        .wdata        (reg_wdata),
        .addr_q       (addr_q),
        .reserved_hit (reserved_hit)
    );

    cfg_cmd_decode #(.DATA_W(DATA_W)) u_dec (
        .acc_valid    (reg_valid),
        .acc_write    (reg_write),
        .acc_sel      (reg_sel),
        .acc_wdata    (reg_wdata),
        .acc_be       (reg_be),
        .busy         (busy),
        .addr_q       (addr_q),
        .reserved_hit (reserved_hit),
        .launch       (launch),
        .addr_wr      (addr_wr),
        .cmd          (cmd),
        .ad_addr      (ad_addr),
        .ad_data      (ad_data),
        .be           (be),
        .is_read      (is_read)
    );

    cfg_bus_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .cmd       (cmd),
        .ad_addr   (ad_addr),
        .ad_data   (ad_data),
        .be        (be),
        .is_read   (is_read),
        .trdy      (trdy),
        .ad_in     (ad_in),
        .cyc_start (cyc_start),
        .busy      (busy),
        .cbe_out   (cbe_out),
        .ad_out    (ad_out),
        .par_out   (par_out),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // R10
    start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |-> !$past(busy));

    // R4
    iack_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && cbe_out == CMD_INTACK) |-> (ad_out == '0));

    // R5
    special_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && cbe_out == CMD_SPECIAL) |-> (ad_out == '0));

    // R8
    parity_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_out == ^$past({ad_out, cbe_out}));

endmodule

// File: tb/tb_cfg_cmd_xlate.sv
module tb_cfg_cmd_xlate;

    localparam int W  = 32;
    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_valid = 1'b0;
    logic          reg_write = 1'b0;
    logic [1:0]    reg_sel = 2'b00;
    logic [W-1:0]  reg_wdata = '0;
    logic [BW-1:0] reg_be = '0;
    logic          trdy = 1'b0;
    logic [W-1:0]  ad_in = '0;
    logic          cyc_start;
    logic [BW-1:0] cbe_out;
    logic [W-1:0]  ad_out;
    logic          par_out;
    logic          busy;
    logic          rd_valid;
    logic [W-1:0]  rd_data;

    always #4 clk = ~clk;

    cfg_cmd_xlate #(.DATA_W(W)) dut (.*);

    typedef struct {
        logic [3:0]   cmd;
        logic [W-1:0] ad;
        logic [BW-1:0] be;
        logic [W-1:0] dwr;
        logic         rd;
        logic [W-1:0] vec;
        string        tag;
    } item_t;

    item_t exp_q[$];
    int checks = 0;
    int fails  = 0;
    logic [W-1:0] model_addr = '0;

    task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic reserved(logic [W-1:0] a);
        return (a[23:16] == 8'h00) && (a[15:11] == 5'h1f) && (a[10:8] == 3'h7) && (a[7:2] == 6'h00);
    endfunction

    // Scoreboard monitor: compares each bus cycle against the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cyc_start) begin
                if (exp_q.size() == 0) begin
                    check("R10", "unexpected cycle start", 1, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(it.tag, "address-phase command", W'(cbe_out), W'(it.cmd));
                    check(it.tag, "address-phase ad", ad_out, it.ad);
                    @(negedge clk);
                    check("R11", "strobe single cycle", W'(cyc_start), 0);
                    check("R7", "data-phase byte enables", W'(cbe_out), W'(it.be));
                    check(it.tag, "data-phase ad", ad_out, it.rd ? '0 : it.dwr);
                    check("R8", "address-phase parity", W'(par_out), W'(^{it.ad, it.cmd}));
                    check("R10", "busy in data phase", W'(busy), 1);
                    while (busy) @(negedge clk);
                    check("R9", "rd_valid at completion", W'(rd_valid), W'(it.rd));
                    if (it.rd) check("R9", "captured vector", rd_data, it.vec);
                end
            end
        end
    end

    // Driver: presents one access, queues the expected cycle, and plays the target.
    task automatic issue(logic [1:0] sel, logic wr, logic [W-1:0] data, logic [BW-1:0] be,
                         int delay, logic [W-1:0] vec, logic inject, logic [W-1:0] inj_addr);
        item_t it;
        logic  cyc;
        cyc = (sel == 2'b01) || (sel == 2'b10 && !wr);
        if (cyc) begin
            it.be  = be;
            it.dwr = data;
            it.rd  = !wr;
            it.vec = vec;
            if (sel == 2'b10) begin
                it.cmd = 4'b0000; it.ad = '0; it.tag = "R6";
            end else if (reserved(model_addr)) begin
                it.cmd = wr ? 4'b0001 : 4'b0000; it.ad = '0; it.tag = wr ? "R5" : "R4";
            end else begin
                it.cmd = wr ? 4'b1011 : 4'b1010; it.ad = {model_addr[W-1:2], 2'b00}; it.tag = "R3";
            end
            exp_q.push_back(it);
        end
        if (sel == 2'b00 && wr) model_addr = data;
        reg_valid = 1'b1; reg_write = wr; reg_sel = sel; reg_wdata = data; reg_be = be;
        @(negedge clk);
        reg_valid = 1'b0;
        if (!cyc) begin
            for (int i = 0; i < 3; i++) begin
                check(sel == 2'b00 ? "R2" : "R6", "no cycle for access", W'({cyc_start, busy}), 0);
                @(negedge clk);
            end
            return;
        end
        check("R11", "strobe one cycle after accept", W'(cyc_start), 1);
        @(negedge clk);
        for (int i = 0; i < delay; i++) begin
            if (inject && i == 0) begin
                reg_valid = 1'b1; reg_write = 1'b0; reg_sel = 2'b01;
            end else if (inject && i == 1) begin
                reg_valid = 1'b1; reg_write = 1'b1; reg_sel = 2'b00; reg_wdata = inj_addr;
                model_addr = inj_addr;
            end else begin
                reg_valid = 1'b0;
            end
            @(negedge clk);
        end
        reg_valid = 1'b0;
        trdy = 1'b1; ad_in = vec;
        @(negedge clk);
        trdy = 1'b0; ad_in = 32'h5a5a_5a5a;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "cyc_start", W'(cyc_start), 0);
        check("R1", "busy", W'(busy), 0);
        check("R1", "rd_valid", W'(rd_valid), 0);
        check("R1", "par_out", W'(par_out), 0);
        check("R1", "cbe_out", W'(cbe_out), 0);
        check("R1", "ad_out", ad_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: ordinary configuration read and write
        issue(2'b00, 1, 32'h8001_2304, 4'h0, 0, 0, 0, 0);
        issue(2'b01, 0, 32'h0, 4'hf, 0, 32'hcafe_0001, 0, 0);
        issue(2'b01, 1, 32'h1234_5678, 4'b0011, 2, 0, 0, 0);

        // R4 / R5: reserved pattern read then write
        issue(2'b00, 1, 32'h8000_ff00, 4'h0, 0, 0, 0, 0);
        issue(2'b01, 0, 32'h0, 4'b0001, 1, 32'h0000_0042, 0, 0);
        issue(2'b01, 1, 32'habcd_0001, 4'b1111, 0, 0, 0, 0);

        // R4: low bits take no part in the reserved test
        issue(2'b00, 1, 32'h8000_ff03, 4'h0, 0, 0, 0, 0);
        issue(2'b01, 0, 32'h0, 4'b0100, 0, 32'h0000_0017, 0, 0);

        // R3: near misses stay configuration cycles
        issue(2'b00, 1, 32'h8000_ff04, 4'h0, 0, 0, 0, 0);
        issue(2'b01, 0, 32'h0, 4'hf, 1, 32'h1111_2222, 0, 0);
        issue(2'b00, 1, 32'h8001_ff00, 4'h0, 0, 0, 0, 0);
        issue(2'b01, 1, 32'h0bad_f00d, 4'b1000, 0, 0, 0, 0);

        // R6: interrupt-ack register read with a non-reserved address; write and sel 11 ignored
        issue(2'b10, 0, 32'h0, 4'hf, 3, 32'h0000_00a5, 0, 0);
        issue(2'b10, 1, 32'hffff_ffff, 4'hf, 0, 0, 0, 0);
        issue(2'b11, 0, 32'h0, 4'hf, 0, 0, 0, 0);

        // R10 / R2: accesses while busy; address write during the cycle
        issue(2'b00, 1, 32'h8002_0810, 4'h0, 0, 0, 0, 0);
        issue(2'b01, 0, 32'h0, 4'hf, 4, 32'h7777_0000, 1, 32'h8000_ff00);
        // R2: new address now reserved, so the next window read is an interrupt ack
        issue(2'b01, 0, 32'h0, 4'b0010, 0, 32'h0000_0099, 0, 0);

        // R9: target ready outside a data phase is ignored
        trdy = 1'b1; ad_in = 32'hdead_beef;
        @(negedge clk);
        trdy = 1'b0;
        check("R9", "rd_valid after idle trdy", W'(rd_valid), 0);
        check("R9", "rd_data kept after idle trdy", rd_data, 32'h0000_0099);
        check("R9", "busy after idle trdy", W'(busy), 0);

        repeat (4) @(negedge clk);
        check("R10", "no leftover expectations", W'(exp_q.size()), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule